// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences power-down for a small processor core. The core raises a one-cycle sleep request when it decodes a sleep instruction. If no enabled interrupt is pending in that cycle, the controller enters sleep. On entry it stops the oscillator, pulses a clear to the watchdog, and updates two status bits. The power-down bit reports that a sleep was actually carried out. The time-out bit reports whether a watchdog expiry ended it.

While asleep, the controller waits for a watchdog expiry or for an enabled interrupt. When one arrives it restarts the oscillator and gives the core a one-cycle resume pulse, so the core continues at the instruction after the sleep. The global interrupt enable does not gate the wake-up itself. It only decides whether the core is asked to branch to the interrupt vector once that next instruction has retired.

A power-on reset or an external reset drives the core reset output. The external reset stops the oscillator gating, but it leaves the status bits untouched so software can read why the core restarted. Every pin is a plain level or strobe. There is no streamed data, so no handshake is needed.

Top module: `pwrdn_seq`

## Requirements
- R1: While `por_n` is low, `pd_o`=1, `to_o`=1, `osc_en_o`=1 and `core_rst_o`=1. `core_rst_o` falls on the SYNC_STAGES-th rising clock edge after `por_n` rises (2 edges by default).
- R2: An interrupt is pending when `irq_flag_i & irq_en_i` is non-zero. A sleep request with nothing pending while awake takes effect at the next edge: `osc_en_o`=0, `pd_o`=0, `to_o`=1, and `wdt_clr_o` high for exactly that one cycle.
- R3: A sleep request in a cycle where an interrupt is pending is a no-op. `osc_en_o` stays 1, `wdt_clr_o` stays 0, `pd_o` and `to_o` keep their values, and no resume pulse is given.
- R4: While asleep, none of these has any effect: a watchdog time-out while `wdt_en_i`=0, or a further sleep request. `osc_en_o` stays 0, and `resume_o` and `wdt_clr_o` stay 0.
- R5: While asleep, a set flag whose enable bit is 0 does not wake the block. A set flag whose enable bit is 1 wakes it.
- R6: At the edge after a wake event (an enabled interrupt pending, or `wdt_en_i & wdt_tmo_i`, while asleep), `osc_en_o` returns to 1 and `resume_o` is high for exactly one cycle.
- R7: A wake-up in which `wdt_en_i & wdt_tmo_i` is true clears `to_o`. A wake-up by interrupt alone leaves `to_o` at 1.
- R8: If `gie_i` was 0 in the wake cycle, `vec_req_o` stays 0. If `gie_i` was 1, `vec_req_o` pulses for one cycle at the edge after the first `instr_retire_i` cycle following the wake.
- R9: An interrupt that becomes pending in the cycle after an accepted sleep request does not cancel the entry. The full entry (R2) happens, and the wake (R6) follows at the next edge.
- R10: `ext_rst_n` low sets `core_rst_o`=1 and `osc_en_o`=1 without waiting for a clock, even while asleep. It leaves `pd_o` and `to_o` unchanged, and sleep requests are ignored while it is low. `core_rst_o` falls on the SYNC_STAGES-th edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous assert |
| sleep_req_i | input | 1 | One-cycle sleep request from the decoder |
| irq_flag_i | input | NUM_IRQ | Interrupt flags |
| irq_en_i | input | NUM_IRQ | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_tmo_i | input | 1 | Watchdog time-out strobe |
| instr_retire_i | input | 1 | Core retired an instruction this cycle |
| osc_en_o | output | 1 | Oscillator driver enable |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Time-out status bit |
| core_rst_o | output | 1 | Core reset, active high |
| resume_o | output | 1 | One-cycle resume pulse to the core |
| vec_req_o | output | 1 | Branch-to-interrupt-vector request |

## Verification
A wrong sleep state shows up within one cycle. Either `osc_en_o` fails to fall after an accepted request, or it stays low after a wake event while `resume_o` never pulses. A misjudged pending check appears at the first edge after the request, as a wrong `wdt_clr_o` or `pd_o`. A lost vector arm appears one edge after the first retire that follows a wake. A wrong time-out cause appears in `to_o` at the wake edge, and that value persists, so it can still be read later.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/pwrdn_rst_sync.sv
module pwrdn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= 1'b0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwrdn_wake_qual.sv
module pwrdn_wake_qual #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_flag_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               wdt_en_i,
  input  logic               wdt_tmo_i,
  output logic               pending_o,
  output logic               wdt_hit_o
);
  logic [NUM_IRQ-1:0] armed;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_src
      assign armed[gi] = irq_flag_i[gi] & irq_en_i[gi];
    end
  endgenerate

  assign pending_o = |armed;
  assign wdt_hit_o = wdt_en_i & wdt_tmo_i;
endmodule

// File: rtl/pwrdn_ctrl_fsm.sv
module pwrdn_ctrl_fsm
  import pwrdn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req_i,
  input  logic pending_i,
  input  logic wdt_hit_i,
  input  logic gie_i,
  input  logic instr_retire_i,
  output logic enter_o,
  output logic wdt_wake_o,
  output logic osc_en_o,
  output logic wdt_clr_o,
  output logic resume_o,
  output logic vec_req_o
);
  pwr_state_e state_q;
  logic       vec_arm_q;
  logic       wake;

  always_comb begin
    enter_o    = rst_n && (state_q == ST_AWAKE) && sleep_req_i && !pending_i;
    wake       = (state_q == ST_ASLEEP) && (pending_i || wdt_hit_i);
    wdt_wake_o = wake && wdt_hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_AWAKE;
      osc_en_o  <= 1'b1;
      wdt_clr_o <= 1'b0;
      resume_o  <= 1'b0;
      vec_arm_q <= 1'b0;
      vec_req_o <= 1'b0;
    end else begin
      wdt_clr_o <= enter_o;
      resume_o  <= wake;
      vec_req_o <= 1'b0;
      case (state_q)
        ST_AWAKE: begin
          if (enter_o) begin
            state_q  <= ST_ASLEEP;
            osc_en_o <= 1'b0;
          end
          if (vec_arm_q && instr_retire_i) begin
            vec_req_o <= 1'b1;
            vec_arm_q <= 1'b0;
          end
        end
        ST_ASLEEP: begin
          if (wake) begin
            state_q   <= ST_AWAKE;
            osc_en_o  <= 1'b1;
            vec_arm_q <= gie_i;
          end
        end
        default: state_q <= ST_AWAKE;
      endcase
    end
  end

  // R3
  noop_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AWAKE && sleep_req_i && pending_i) |=>
      (osc_en_o && !wdt_clr_o && !resume_o));

  // R5
  stay_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ASLEEP && !pending_i && !wdt_hit_i) |=> (!osc_en_o && !resume_o));

  // R6
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !resume_o);

  // R8
  vec_after_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> $past(instr_retire_i));
endmodule

// File: rtl/pwrdn_flags.sv
module pwrdn_flags (
  input  logic clk,
  input  logic por_n,
  input  logic enter_i,
  input  logic wdt_wake_i,
  output logic pd_o,
  output logic to_o
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pd_o <= 1'b1;
      to_o <= 1'b1;
    end else if (enter_i) begin
      pd_o <= 1'b0;
      to_o <= 1'b1;
    end else if (wdt_wake_i) begin
      to_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
  parameter int NUM_IRQ     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               ext_rst_n,
  input  logic               sleep_req_i,
  input  logic [NUM_IRQ-1:0] irq_flag_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               gie_i,
  input  logic               wdt_en_i,
  input  logic               wdt_tmo_i,
  input  logic               instr_retire_i,
  output logic               osc_en_o,
  output logic               wdt_clr_o,
  output logic               pd_o,
  output logic               to_o,
  output logic               core_rst_o,
  output logic               resume_o,
  output logic               vec_req_o
);
  logic arst_n, rst_n, pending, wdt_hit, enter, wdt_wake;

  assign arst_n = por_n & ext_rst_n;

  pwrdn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n)
  );
  assign core_rst_o = ~rst_n;

  pwrdn_wake_qual #(.NUM_IRQ(NUM_IRQ)) u_wake_qual (
    .irq_flag_i(irq_flag_i), .irq_en_i(irq_en_i),
    .wdt_en_i(wdt_en_i), .wdt_tmo_i(wdt_tmo_i),
    .pending_o(pending), .wdt_hit_o(wdt_hit)
  );

  pwrdn_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i),
    .pending_i(pending), .wdt_hit_i(wdt_hit), .gie_i(gie_i),
    .instr_retire_i(instr_retire_i), .enter_o(enter), .wdt_wake_o(wdt_wake),
    .osc_en_o(osc_en_o), .wdt_clr_o(wdt_clr_o), .resume_o(resume_o),
    .vec_req_o(vec_req_o)
  );

  pwrdn_flags u_flags (
    .clk(clk), .por_n(por_n), .enter_i(enter), .wdt_wake_i(wdt_wake),
    .pd_o(pd_o), .to_o(to_o)
  );

  // R2
  entry_status_chk: assert property (@(posedge clk) disable iff (core_rst_o)
    wdt_clr_o |-> (!osc_en_o && !pd_o && to_o));

  // R2
  pd_only_on_entry_chk: assert property (@(posedge clk) disable iff (core_rst_o)
    $fell(pd_o) |-> wdt_clr_o);

  // R7
  to_only_on_wake_chk: assert property (@(posedge clk) disable iff (core_rst_o)
    $fell(to_o) |-> resume_o);
endmodule

// File: tb/pwrdn_seq_bench.sv
module pwrdn_seq_bench;
  localparam int N = 8;
  logic clk = 1'b0;
  logic por_n, ext_rst_n, sleep_req, gie, wdt_en, wdt_tmo, retire;
  logic [N-1:0] flg, en;
  logic osc, wclr, pd, to, crst, resume, vreq;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pwrdn_seq #(.NUM_IRQ(N), .SYNC_STAGES(2)) u_pwrdn_seq (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sleep_req_i(sleep_req),
    .irq_flag_i(flg), .irq_en_i(en), .gie_i(gie), .wdt_en_i(wdt_en),
    .wdt_tmo_i(wdt_tmo), .instr_retire_i(retire), .osc_en_o(osc),
    .wdt_clr_o(wclr), .pd_o(pd), .to_o(to), .core_rst_o(crst),
    .resume_o(resume), .vec_req_o(vreq)
  );

  function automatic logic exp_pending(logic [N-1:0] f, logic [N-1:0] e);
    return |(f & e);
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive_step();
    @(posedge clk); #1;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    sleep_req = 0; flg = '0; en = '0; wdt_tmo = 0; retire = 0;
  endtask

  // Request sleep with nothing pending, check entry (R2)
  task automatic do_sleep(string tag);
    sleep_req = 1;
    sample();
    drive_step();
    sleep_req = 0;
    sample();
    chk(tag, "osc", osc, 1'b0);
    chk(tag, "wdt_clr", wclr, 1'b1);
    chk(tag, "pd", pd, 1'b0);
    chk(tag, "to", to, 1'b1);
    drive_step();
    sample();
    chk(tag, "wdt_clr one cycle", wclr, 1'b0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    logic exp_to;
    void'($urandom(32'd1234));
    por_n = 0; ext_rst_n = 1; gie = 0; wdt_en = 0; idle_inputs();
    repeat (3) drive_step();
    sample();
    chk("R1", "core_rst", crst, 1'b1);
    chk("R1", "pd", pd, 1'b1);
    chk("R1", "to", to, 1'b1);
    chk("R1", "osc", osc, 1'b1);
    drive_step(); por_n = 1;
    drive_step(); sample();
    chk("R1", "core_rst after 1 edge", crst, 1'b1);
    drive_step(); sample();
    chk("R1", "core_rst after 2 edges", crst, 1'b0);

    // R3 no-op sleep
    drive_step();
    flg = 8'h04; en = 8'h04; sleep_req = 1;
    drive_step(); sleep_req = 0; flg = '0; en = '0;
    sample();
    chk("R3", "osc", osc, 1'b1);
    chk("R3", "wdt_clr", wclr, 1'b0);
    chk("R3", "pd", pd, 1'b1);
    chk("R3", "resume", resume, 1'b0);

    // Watchdog wake, gie clear
    drive_step();
    do_sleep("R2");
    wdt_tmo = 1; wdt_en = 0; sleep_req = 1;
    drive_step(); wdt_tmo = 0; sleep_req = 0;
    sample();
    chk("R4", "osc", osc, 1'b0);
    chk("R4", "resume", resume, 1'b0);
    chk("R4", "wdt_clr", wclr, 1'b0);
    flg = 8'h81; en = 8'h7E;
    drive_step(); sample();
    chk("R5", "disabled flag osc", osc, 1'b0);
    chk("R5", "disabled flag resume", resume, 1'b0);
    flg = '0; en = '0; wdt_en = 1; wdt_tmo = 1; gie = 0;
    drive_step(); wdt_tmo = 0;
    sample();
    chk("R6", "osc", osc, 1'b1);
    chk("R6", "resume", resume, 1'b1);
    chk("R7", "to after wdt wake", to, 1'b0);
    drive_step(); retire = 1;
    sample();
    chk("R6", "resume one cycle", resume, 1'b0);
    drive_step(); retire = 0; sample();
    chk("R8", "no vec with gie clear", vreq, 1'b0);

    // Interrupt wake, gie set
    drive_step();
    do_sleep("R2");
    flg = 8'h10; en = 8'h10; gie = 1;
    drive_step(); flg = '0; en = '0; gie = 0;
    sample();
    chk("R5", "enabled flag wakes", resume, 1'b1);
    chk("R7", "to after irq wake", to, 1'b1);
    drive_step(); sample();
    chk("R8", "no vec before retire", vreq, 1'b0);
    retire = 1;
    drive_step(); retire = 0; sample();
    chk("R8", "vec after retire", vreq, 1'b1);
    drive_step(); sample();
    chk("R8", "vec one cycle", vreq, 1'b0);

    // R9 race: flag rises the cycle after the request
    sleep_req = 1;
    drive_step(); sleep_req = 0; flg = 8'h02; en = 8'hFF;
    sample();
    chk("R9", "entry osc", osc, 1'b0);
    chk("R9", "entry wdt_clr", wclr, 1'b1);
    chk("R9", "entry pd", pd, 1'b0);
    drive_step(); flg = '0; en = '0; sample();
    chk("R9", "wake osc", osc, 1'b1);
    chk("R9", "wake resume", resume, 1'b1);

    // R10 external reset during sleep
    drive_step();
    do_sleep("R2");
    wdt_en = 1; wdt_tmo = 1;
    drive_step(); wdt_tmo = 0; sample();
    drive_step();
    do_sleep("R2");
    exp_to = to;
    #1 ext_rst_n = 0; #1;
    chk("R10", "core_rst async", crst, 1'b1);
    chk("R10", "osc async", osc, 1'b1);
    sleep_req = 1;
    drive_step(); sleep_req = 0; sample();
    chk("R10", "pd kept", pd, 1'b0);
    chk("R10", "to kept", to, exp_to);
    chk("R10", "sleep ignored", wclr, 1'b0);
    chk("R10", "osc held", osc, 1'b1);
    ext_rst_n = 1;
    drive_step(); sample();
    chk("R10", "core_rst after 1 edge", crst, 1'b1);
    drive_step(); sample();
    chk("R10", "core_rst released", crst, 1'b0);
    chk("R10", "osc after release", osc, 1'b1);

    // Random phase
    for (int it = 0; it < 40; it++) begin
      logic [N-1:0] rf, re;
      logic pend, use_wdt, g;
      rf = N'($urandom) & N'($urandom);
      re = N'($urandom) & N'($urandom);
      pend = exp_pending(rf, re);
      drive_step();
      flg = rf; en = re; sleep_req = 1;
      drive_step(); sleep_req = 0; flg = '0; en = '0; sample();
      if (pend) begin
        chk("R3", "rand noop osc", osc, 1'b1);
        chk("R3", "rand noop wdt_clr", wclr, 1'b0);
      end else begin
        chk("R2", "rand entry osc", osc, 1'b0);
        chk("R2", "rand entry to", to, 1'b1);
        use_wdt = 1'($urandom);
        g = 1'($urandom);
        drive_step();
        gie = g;
        if (use_wdt) begin
          wdt_en = 1; wdt_tmo = 1;
        end else begin
          flg = N'(1) << ($urandom % N); en = flg;
        end
        drive_step(); wdt_tmo = 0; flg = '0; en = '0; gie = 0; sample();
        chk("R6", "rand resume", resume, 1'b1);
        chk("R7", "rand to", to, !use_wdt);
        retire = 1;
        drive_step(); retire = 0; sample();
        chk("R8", "rand vec", vreq, g);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule